// File: doc/BRIEF.md
# Next-PC Selection Unit

This combinational unit decides where a single-cycle core fetches from next. It takes the current program counter, the fetched instruction word, a two-bit flow class produced by the decoder, a branch-polarity bit, the ALU zero flag and the value read from the rs register. From these it forms four candidate addresses: the sequential address, a PC-relative branch target, a region-based jump target and a register-held target.

First the unit resolves whether a conditional branch is taken by correcting the zero flag for polarity. It then encodes a two-bit select from the flow class and that condition, and uses the select to pick one candidate. The select is also driven out, so surrounding logic and tests can see which path was chosen. The PC register and the instruction decoder sit outside this unit.

All additions wrap modulo 2^32. The unit holds no state.

Top module: `npc_select_unit`

## Requirements
- R1: The branch condition equals `zero_i` when `bpol_i` is 0, and equals the inverse of `zero_i` when `bpol_i` is 1. It is observable through `sel_o` whenever `flow_i` is 2'b00.
- R2: When `flow_i` is 2'b00 and the branch condition is true, `sel_o` is 2'b00 and `next_pc_o` is the branch target.
- R3: When `flow_i` is 2'b00 and the branch condition is false, `sel_o` is 2'b11 and `next_pc_o` is `pc_i + 4`.
- R4: When `flow_i` is 2'b01, `sel_o` is 2'b01. `next_pc_o` is formed from three parts, high to low: `pc_i[31:28]`, then `instr_i[25:0]`, then two zero bits.
- R5: When `flow_i` is 2'b10, `sel_o` is 2'b10 and `next_pc_o` equals `rs_val_i`.
- R6: When `flow_i` is 2'b11, `sel_o` is 2'b11 and `next_pc_o` equals `pc_i + 4`.
- R7: The branch target is `pc_i + 4` plus `instr_i[15:0]` sign-extended and multiplied by 4. Negative offsets move backwards, and the sum wraps modulo 2^32.
- R8: The sequential address wraps, so that `pc_i` = 32'hFFFF_FFFC gives 32'h0000_0000.
- R9: For `flow_i` values 2'b01, 2'b10 and 2'b11, changing `zero_i` or `bpol_i` has no effect on `sel_o` or on `next_pc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| instr_i | input | 32 | Instruction word: immediate in bits 15:0, jump index in bits 25:0 |
| flow_i | input | 2 | Flow class: 00 conditional branch, 01 jump, 10 register jump, 11 sequential |
| bpol_i | input | 1 | Branch polarity: 0 takes the branch on zero, 1 takes it on non-zero |
| zero_i | input | 1 | ALU zero flag |
| rs_val_i | input | 32 | Value of the rs register |
| sel_o | output | 2 | Select: 00 branch, 01 jump, 10 register, 11 sequential |
| next_pc_o | output | 32 | Chosen next program counter |

## Verification
Two paths can coincide in a single evaluation.

The first case is a taken branch whose immediate is zero. Its target equals the sequential address, so the address alone cannot show which path was chosen. The bench drives exactly that and judges it by `sel_o` being 2'b00 rather than 2'b11.

The second case is a jump issued from the last word of a 256 MB region. There the sequential address crosses into the next region while the jump target must keep the current region bits. The bench sets `pc_i` = 32'h1FFF_FFFC and checks that the upper nibble of the result stays 4'h1.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int ADDR_W   = 32;
    localparam int INSTR_W  = 32;
    localparam int IMM_W    = 16;
    localparam int IDX_W    = 26;
    localparam int REGION_W = 4;
    localparam int WORD_SH  = 2;

    typedef enum logic [1:0] {
        FLOW_BRANCH = 2'b00,
        FLOW_JUMP   = 2'b01,
        FLOW_REG    = 2'b10,
        FLOW_SEQ    = 2'b11
    } flow_e;

    typedef enum logic [1:0] {
        PICK_BRANCH = 2'b00,
        PICK_JUMP   = 2'b01,
        PICK_REG    = 2'b10,
        PICK_SEQ    = 2'b11
    } pick_e;

    typedef struct packed {
        logic [ADDR_W-1:0] seq;
        logic [ADDR_W-1:0] branch;
        logic [ADDR_W-1:0] jump;
        logic [ADDR_W-1:0] regt;
    } cand_t;

    function automatic logic [ADDR_W-1:0] word_offset(input logic [IMM_W-1:0] imm);
        logic [ADDR_W-1:0] ext;
        ext = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
        return ext << WORD_SH;
    endfunction

endpackage

// File: rtl/npc_branch_eval.sv
module npc_branch_eval (
    input  logic zero_i,
    input  logic bpol_i,
    output logic taken_o
);
    always_comb begin
        taken_o = bpol_i ? ~zero_i : zero_i;
    end
endmodule

// File: rtl/npc_sel_encoder.sv
module npc_sel_encoder
    import npc_pkg::*;
(
    input  flow_e flow_i,
    input  logic  taken_i,
    output pick_e sel_o
);
    logic [1:0] f;
    logic [1:0] s;

    always_comb begin
        f    = flow_i;
        s[0] = f[0] | (~taken_i & ~f[1]);
        s[1] = f[1] | (~taken_i & ~f[0]);
        sel_o = pick_e'(s);
    end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = INSTR_W
) (
    input  logic [AW-1:0] pc_i,
    input  logic [IW-1:0] instr_i,
    input  logic [AW-1:0] rs_val_i,
    output cand_t         cand_o
);
    localparam int STEP = 1 << WORD_SH;

    logic [AW-1:0] seq_addr;

    always_comb begin
        seq_addr      = pc_i + AW'(STEP);
        cand_o.seq    = seq_addr;
        cand_o.branch = seq_addr + word_offset(instr_i[IMM_W-1:0]);
        cand_o.jump   = {pc_i[AW-1 -: REGION_W], instr_i[IDX_W-1:0], {WORD_SH{1'b0}}};
        cand_o.regt   = rs_val_i;
    end
endmodule

// File: rtl/npc_pick.sv
module npc_pick
    import npc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  cand_t         cand_i,
    input  pick_e         sel_i,
    output logic [AW-1:0] next_o
);
    always_comb begin
        unique case (sel_i)
            PICK_BRANCH: next_o = cand_i.branch;
            PICK_JUMP:   next_o = cand_i.jump;
            PICK_REG:    next_o = cand_i.regt;
            default:     next_o = cand_i.seq;
        endcase
    end
endmodule

// File: rtl/npc_select_unit.sv
module npc_select_unit
    import npc_pkg::*;
(
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [1:0]         flow_i,
    input  logic               bpol_i,
    input  logic               zero_i,
    input  logic [ADDR_W-1:0]  rs_val_i,
    output logic [1:0]         sel_o,
    output logic [ADDR_W-1:0]  next_pc_o
);
    logic  taken;
    pick_e pick;
    cand_t cand;

    npc_branch_eval u_cond (
        .zero_i  (zero_i),
        .bpol_i  (bpol_i),
        .taken_o (taken)
    );

    npc_sel_encoder u_enc (
        .flow_i  (flow_e'(flow_i)),
        .taken_i (taken),
        .sel_o   (pick)
    );

    npc_target_gen #(.AW(ADDR_W), .IW(INSTR_W)) u_tgt (
        .pc_i     (pc_i),
        .instr_i  (instr_i),
        .rs_val_i (rs_val_i),
        .cand_o   (cand)
    );

    npc_pick #(.AW(ADDR_W)) u_pick (
        .cand_i (cand),
        .sel_i  (pick),
        .next_o (next_pc_o)
    );

    assign sel_o = pick;
endmodule

// File: rtl/npc_select_unit_chk.sv
module npc_select_unit_chk
    import npc_pkg::*;
(
    input logic [ADDR_W-1:0]  pc_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic [1:0]         flow_i,
    input logic               bpol_i,
    input logic               zero_i,
    input logic [ADDR_W-1:0]  rs_val_i,
    input logic [1:0]         sel_o,
    input logic [ADDR_W-1:0]  next_pc_o
);
    logic known;
    logic cond;

    always_comb begin
        known = !$isunknown({pc_i, instr_i, flow_i, bpol_i, zero_i, rs_val_i});
        cond  = zero_i ^ bpol_i;
        if (known) begin
            if (flow_i == 2'b00 && cond)
                a_r2_taken_picks_branch: assert (sel_o == 2'b00);
            if (flow_i == 2'b00 && !cond)
                a_r3_untaken_picks_seq: assert (sel_o == 2'b11 && next_pc_o == pc_i + 32'd4);
            if (flow_i == 2'b01)
                a_r4_jump_keeps_region: assert (sel_o == 2'b01
                    && next_pc_o[31:28] == pc_i[31:28] && next_pc_o[1:0] == 2'b00);
            if (flow_i == 2'b10)
                a_r5_reg_target: assert (sel_o == 2'b10 && next_pc_o == rs_val_i);
            if (flow_i == 2'b11)
                a_r6_seq_class: assert (sel_o == 2'b11 && next_pc_o == pc_i + 32'd4);
        end
    end
endmodule

bind npc_select_unit npc_select_unit_chk i_chk (
    .pc_i      (pc_i),
    .instr_i   (instr_i),
    .flow_i    (flow_i),
    .bpol_i    (bpol_i),
    .zero_i    (zero_i),
    .rs_val_i  (rs_val_i),
    .sel_o     (sel_o),
    .next_pc_o (next_pc_o)
);

// File: tb/test_npc_select_unit.sv
module test_npc_select_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic [31:0] instr_i = '0;
    logic [1:0]  flow_i = 2'b00;
    logic        bpol_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [31:0] rs_val_i = '0;
    logic [1:0]  sel_o;
    logic [31:0] next_pc_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    npc_select_unit i_npc_select_unit (
        .pc_i      (pc_i),
        .instr_i   (instr_i),
        .flow_i    (flow_i),
        .bpol_i    (bpol_i),
        .zero_i    (zero_i),
        .rs_val_i  (rs_val_i),
        .sel_o     (sel_o),
        .next_pc_o (next_pc_o)
    );

    function automatic logic [31:0] exp_seq(input logic [31:0] pc);
        return pc + 32'd4;
    endfunction

    function automatic logic [31:0] exp_br(input logic [31:0] pc, input logic [31:0] ins);
        logic [31:0] off;
        off = {{14{ins[15]}}, ins[15:0], 2'b00};
        return pc + 32'd4 + off;
    endfunction

    function automatic logic [31:0] exp_jmp(input logic [31:0] pc, input logic [31:0] ins);
        return {pc[31:28], ins[25:0], 2'b00};
    endfunction

    task automatic apply(input logic [31:0] pc, input logic [31:0] ins, input logic [1:0] fl,
                         input logic pol, input logic z, input logic [31:0] rs);
        @(negedge clk);
        pc_i = pc; instr_i = ins; flow_i = fl; bpol_i = pol; zero_i = z; rs_val_i = rs;
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] es, input logic [31:0] en);
        n_checks++;
        if (sel_o !== es || next_pc_o !== en) begin
            n_fail++;
            $display("FAIL %s: sel=%b next=%h expected sel=%b next=%h", req, sel_o, next_pc_o, es, en);
        end
    endtask

    task automatic t_idle;
        // R3: all-zero inputs: branch class, not taken
        #1;
        check("R3 idle", 2'b11, 32'h4);
    endtask

    task automatic t_polarity;
        // R1/R2/R3: all four zero/polarity combinations on a branch
        logic [31:0] ins = 32'h1000_0010;
        apply(32'h0040_0100, ins, 2'b00, 1'b0, 1'b1, '0);
        check("R1 R2 pol0 zero1", 2'b00, exp_br(32'h0040_0100, ins));
        apply(32'h0040_0100, ins, 2'b00, 1'b0, 1'b0, '0);
        check("R1 R3 pol0 zero0", 2'b11, exp_seq(32'h0040_0100));
        apply(32'h0040_0100, ins, 2'b00, 1'b1, 1'b0, '0);
        check("R1 R2 pol1 zero0", 2'b00, exp_br(32'h0040_0100, ins));
        apply(32'h0040_0100, ins, 2'b00, 1'b1, 1'b1, '0);
        check("R1 R3 pol1 zero1", 2'b11, exp_seq(32'h0040_0100));
    endtask

    task automatic t_branch_offsets;
        // R7: backward, zero and wrapping offsets
        apply(32'h0000_1000, 32'h0000_FFFE, 2'b00, 1'b0, 1'b1, '0);
        check("R7 backward", 2'b00, 32'h0000_0FFC);
        apply(32'h0000_2000, 32'h0000_0000, 2'b00, 1'b0, 1'b1, '0);
        check("R7 R2 zero offset", 2'b00, 32'h0000_2004);
        apply(32'h0000_0008, 32'h0000_8000, 2'b00, 1'b1, 1'b0, '0);
        check("R7 wrap below zero", 2'b00, exp_br(32'h0000_0008, 32'h0000_8000));
        apply(32'hFFFF_FFF0, 32'h0000_0010, 2'b00, 1'b1, 1'b0, '0);
        check("R7 wrap above top", 2'b00, 32'h0000_0034);
    endtask

    task automatic t_jump;
        // R4: region bits from current PC
        apply(32'h1FFF_FFFC, 32'h0BFF_FFFF, 2'b01, 1'b0, 1'b0, 32'hDEAD_BEEF);
        check("R4 region edge", 2'b01, exp_jmp(32'h1FFF_FFFC, 32'h0BFF_FFFF));
        apply(32'hA000_0000, 32'h0812_3456, 2'b01, 1'b1, 1'b1, '0);
        check("R4 R9 jump", 2'b01, 32'hA048_D158);
    endtask

    task automatic t_register;
        // R5
        apply(32'h0000_4000, 32'h0000_0008, 2'b10, 1'b0, 1'b1, 32'h1234_5679);
        check("R5 register", 2'b10, 32'h1234_5679);
        apply(32'h0000_4000, 32'h0000_0008, 2'b10, 1'b1, 1'b1, 32'h0000_0000);
        check("R5 R9 register zero", 2'b10, 32'h0);
    endtask

    task automatic t_sequential;
        // R6, R8
        apply(32'h0040_0020, 32'hFFFF_FFFF, 2'b11, 1'b0, 1'b1, 32'h5);
        check("R6 sequential", 2'b11, 32'h0040_0024);
        apply(32'hFFFF_FFFC, 32'h0, 2'b11, 1'b0, 1'b0, 32'h5);
        check("R8 wrap", 2'b11, 32'h0000_0000);
    endtask

    task automatic t_ignore_flags;
        // R9: every zero/polarity combination on non-branch classes
        for (int fl = 1; fl < 4; fl++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] e;
                e = (fl == 1) ? exp_jmp(32'h3000_0100, 32'h0000_0040)
                  : (fl == 2) ? 32'h7777_0000 : exp_seq(32'h3000_0100);
                apply(32'h3000_0100, 32'h0000_0040, 2'(fl), k[1], k[0], 32'h7777_0000);
                check("R9 flags ignored", 2'(fl), e);
            end
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_polarity();
        t_branch_offsets();
        t_jump();
        t_register();
        t_sequential();
        t_ignore_flags();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (10000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule